// File: doc/BRIEF.md
# Function Configuration State Controller

This block keeps the life-cycle state of a small table of I/O functions and serves configure, deconfigure and reset requests for them. A request names a function by a 32-bit identifier and carries the length of the request block that came with it. The controller finds the function in its table, decides a 16-bit response code from the function's present state, writes the new state back, and returns the code together with the function's resulting state and flags in a one-cycle completion pulse.

Each table entry holds a valid bit, the identifier, a state and four flags: interrupt registration, address translation enabled, handle enable bit and measurement-block address present. When a function leaves its active states, the controller pulses teardown outputs for the interrupt registration and the translation setup so that neighbouring logic can undo them, and names the table slot concerned. The table is filled through a load command and read back through a query command, which keeps every state change visible at the ports.

Top module: `func_cfg_ctrl`

## Requirements
- R1: States are encoded reserved=0, standby=1, disabled=2, enabled=3, blocked=4; flags are reported as {mba, hen, xlat, irq} in bits 3..0. Opcode 3 (load) writes slot cmdSlot with cmdId, cmdLoadState and cmdLoadFlags, marks it valid and answers 0x0010 with the loaded state and flags; opcode 4 (query) answers 0x0010 with the stored state and flags of the named function and changes nothing.
- R2: A configure (opcode 0) or deconfigure (opcode 1) whose cmdLen is below 16 answers 0x0300, reports state 0 and flags 0, and leaves the table unchanged; this check comes before the identifier lookup, and a length of exactly 16 is accepted.
- R3: An identifier that matches no valid entry answers 0x09F0 with state 0 and flags 0; empty slots never match, not even identifier 0; when several valid entries carry the same identifier, the lowest slot is used.
- R4: Configure on a reserved function answers 0x0AF0; on a standby function it moves it to disabled and answers 0x0010; on any other state it answers 0x0020 and changes nothing.
- R5: Deconfigure on a reserved function answers 0x0AF0 and on a standby function answers 0x0020, both without change.
- R6: Deconfigure from disabled, enabled or blocked moves the function to standby, clears its irq and xlat flags, answers 0x0010, pulses irqTeardown exactly when irq was set and xlatTeardown exactly when xlat was set, and drives tdSlot with the function's slot.
- R7: Reset (opcode 2) on a reserved function answers 0x0020 and changes nothing; on a standby function it keeps the state, clears irq, xlat and mba, pulses the teardowns as in R6 and answers 0x0010; on disabled, enabled or blocked it moves to disabled and clears all four flags with the same teardown pulses and 0x0010.
- R8: A command is taken on a clock edge where cmdValid and cmdReady are both high; cmdReady is low in the following cycle, and in the cycle after that done is high for exactly one cycle with the response fields valid and cmdReady high again.
- R9: Opcodes 5 to 7 answer 0x01F0 with state 0 and flags 0 and change nothing.
- R10: irqTeardown and xlatTeardown are only ever high in a done cycle that answers 0x0010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset, empties the table |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Controller idle, command can be taken |
| cmdOp | input | 3 | Opcode: 0 configure, 1 deconfigure, 2 reset, 3 load, 4 query |
| cmdId | input | ID_W | Function identifier |
| cmdLen | input | LEN_W | Request-block length |
| cmdSlot | input | SLOT_W | Table slot written by load |
| cmdLoadState | input | 3 | State written by load |
| cmdLoadFlags | input | 4 | Flags written by load, {mba, hen, xlat, irq} |
| done | output | 1 | One-cycle completion pulse |
| rspCode | output | 16 | Response code |
| rspState | output | 3 | Resulting state of the addressed function |
| rspFlags | output | 4 | Resulting flags of the addressed function |
| irqTeardown | output | 1 | Deregister the function's interrupts |
| xlatTeardown | output | 1 | Disable the function's address translation |
| tdSlot | output | SLOT_W | Slot of the function being torn down |

## Verification
The two teardown outputs can fire in the same completion cycle, when a deconfigure or reset meets a function that has both interrupt registration and translation enabled. The bench provokes this by sweeping all five states against all sixteen flag patterns for every state-changing opcode, so the cases with both, one or neither flag set all occur, and it judges each pulse against the flag values it loaded and the slot it chose, then reads the entry back with a query to confirm the stored result.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

  typedef enum logic [2:0] {
    FS_RESV = 3'd0,
    FS_STBY = 3'd1,
    FS_DISA = 3'd2,
    FS_ENAB = 3'd3,
    FS_BLKD = 3'd4
  } fstate_e;

  typedef enum logic [2:0] {
    OP_CFG   = 3'd0,
    OP_DECFG = 3'd1,
    OP_RESET = 3'd2,
    OP_LOAD  = 3'd3,
    OP_QUERY = 3'd4
  } op_e;

  // flag bit positions in the 4-bit flag word
  localparam int FL_IRQ  = 0;
  localparam int FL_XLAT = 1;
  localparam int FL_HEN  = 2;
  localparam int FL_MBA  = 3;

  localparam logic [15:0] RC_NORMAL  = 16'h0010;
  localparam logic [15:0] RC_NOACT   = 16'h0020;
  localparam logic [15:0] RC_BADOP   = 16'h01F0;
  localparam logic [15:0] RC_SHORT   = 16'h0300;
  localparam logic [15:0] RC_UNKNOWN = 16'h09F0;
  localparam logic [15:0] RC_INRESV  = 16'h0AF0;

  // control-to-datapath strobes
  typedef struct packed {
    logic    load;
    logic    upd;
    fstate_e newState;
    logic    clrIrq;
    logic    clrXlat;
    logic    clrHen;
    logic    clrMba;
  } strobe_t;

endpackage

// File: rtl/fcc_table.sv
module fcc_table
  import fcc_pkg::*;
#(
  parameter int NUM_FUNCS = 8,
  parameter int ID_W      = 32,
  parameter int SLOT_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [SLOT_W-1:0] loadSlot,
  input  logic [ID_W-1:0]   loadId,
  input  logic [2:0]        loadState,
  input  logic [3:0]        loadFlags,
  input  logic [ID_W-1:0]   lookupId,
  output logic              hit,
  output logic [SLOT_W-1:0] hitSlot,
  output logic [2:0]        hitState,
  output logic [3:0]        hitFlags
);

  logic              entValid [NUM_FUNCS];
  logic [ID_W-1:0]   entId    [NUM_FUNCS];
  logic [2:0]        entState [NUM_FUNCS];
  logic [3:0]        entFlags [NUM_FUNCS];
  logic [NUM_FUNCS-1:0] match;
  logic [3:0]        clrMask;

  // parallel identifier compare, one comparator per slot
  for (genvar g = 0; g < NUM_FUNCS; g++) begin : g_cmp
    assign match[g] = entValid[g] && (entId[g] == lookupId);
  end

  // lowest matching slot wins
  always_comb begin
    hitSlot = '0;
    for (int i = NUM_FUNCS - 1; i >= 0; i--) begin
      if (match[i]) hitSlot = SLOT_W'(i);
    end
  end

  assign hit      = |match;
  assign hitState = entState[hitSlot];
  assign hitFlags = entFlags[hitSlot];

  always_comb begin
    clrMask          = '0;
    clrMask[FL_IRQ]  = stb.clrIrq;
    clrMask[FL_XLAT] = stb.clrXlat;
    clrMask[FL_HEN]  = stb.clrHen;
    clrMask[FL_MBA]  = stb.clrMba;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FUNCS; i++) begin
        entValid[i] <= 1'b0;
        entId[i]    <= '0;
        entState[i] <= FS_RESV;
        entFlags[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_FUNCS; i++) begin
        if (stb.load && loadSlot == SLOT_W'(i)) begin
          entValid[i] <= 1'b1;
          entId[i]    <= loadId;
          entState[i] <= loadState;
          entFlags[i] <= loadFlags;
        end else if (stb.upd && hit && hitSlot == SLOT_W'(i)) begin
          entState[i] <= stb.newState;
          entFlags[i] <= entFlags[i] & ~clrMask;
        end
      end
    end
  end

endmodule

// File: rtl/fcc_control.sv
module fcc_control
  import fcc_pkg::*;
#(
  parameter int ID_W    = 32,
  parameter int LEN_W   = 16,
  parameter int SLOT_W  = 3,
  parameter int MIN_LEN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [ID_W-1:0]   cmdId,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic [2:0]        cmdLoadState,
  input  logic [3:0]        cmdLoadFlags,
  input  logic              hit,
  input  logic [SLOT_W-1:0] hitSlot,
  input  logic [2:0]        hitState,
  input  logic [3:0]        hitFlags,
  output strobe_t           stb,
  output logic [ID_W-1:0]   lookupId,
  output logic [SLOT_W-1:0] loadSlot,
  output logic [ID_W-1:0]   loadId,
  output logic [2:0]        loadState,
  output logic [3:0]        loadFlags,
  output logic              done,
  output logic [15:0]       rspCode,
  output logic [2:0]        rspState,
  output logic [3:0]        rspFlags,
  output logic              irqTeardown,
  output logic              xlatTeardown,
  output logic [SLOT_W-1:0] tdSlot
);

  logic              busy;
  logic [2:0]        opQ;
  logic [ID_W-1:0]   idQ;
  logic [LEN_W-1:0]  lenQ;
  logic [SLOT_W-1:0] slotQ;
  logic [2:0]        lstQ;
  logic [3:0]        lflQ;

  logic [15:0] rcNext;
  logic [2:0]  stNext;
  logic [3:0]  flNext;
  logic        irqNext, xlatNext, lenShort;
  fstate_e     curState;

  assign cmdReady  = !busy;
  assign lookupId  = idQ;
  assign loadSlot  = slotQ;
  assign loadId    = idQ;
  assign loadState = lstQ;
  assign loadFlags = lflQ;
  assign curState  = fstate_e'(hitState);
  assign lenShort  = (opQ == OP_CFG || opQ == OP_DECFG) && (lenQ < LEN_W'(MIN_LEN));

  always_comb begin
    stb          = '0;
    stb.newState = curState;
    rcNext       = RC_NORMAL;
    stNext       = hitState;
    flNext       = hitFlags;
    irqNext      = 1'b0;
    xlatNext     = 1'b0;
    if (opQ == OP_LOAD) begin
      stb.load = 1'b1;
      stNext   = lstQ;
      flNext   = lflQ;
    end else if (opQ > OP_QUERY) begin
      rcNext = RC_BADOP;
      stNext = '0;
      flNext = '0;
    end else if (lenShort) begin
      rcNext = RC_SHORT;
      stNext = '0;
      flNext = '0;
    end else if (!hit) begin
      rcNext = RC_UNKNOWN;
      stNext = '0;
      flNext = '0;
    end else begin
      case (opQ)
        OP_CFG: begin
          if (curState == FS_RESV) rcNext = RC_INRESV;
          else if (curState == FS_STBY) begin
            stb.upd      = 1'b1;
            stb.newState = FS_DISA;
            stNext       = FS_DISA;
          end else rcNext = RC_NOACT;
        end
        OP_DECFG: begin
          if (curState == FS_RESV) rcNext = RC_INRESV;
          else if (curState == FS_STBY) rcNext = RC_NOACT;
          else begin
            stb.upd      = 1'b1;
            stb.newState = FS_STBY;
            stb.clrIrq   = 1'b1;
            stb.clrXlat  = 1'b1;
            irqNext      = hitFlags[FL_IRQ];
            xlatNext     = hitFlags[FL_XLAT];
            stNext       = FS_STBY;
            flNext[FL_IRQ]  = 1'b0;
            flNext[FL_XLAT] = 1'b0;
          end
        end
        OP_RESET: begin
          if (curState == FS_RESV) rcNext = RC_NOACT;
          else begin
            stb.upd     = 1'b1;
            stb.clrIrq  = 1'b1;
            stb.clrXlat = 1'b1;
            stb.clrMba  = 1'b1;
            irqNext     = hitFlags[FL_IRQ];
            xlatNext    = hitFlags[FL_XLAT];
            flNext[FL_IRQ]  = 1'b0;
            flNext[FL_XLAT] = 1'b0;
            flNext[FL_MBA]  = 1'b0;
            if (curState != FS_STBY) begin
              stb.newState   = FS_DISA;
              stb.clrHen     = 1'b1;
              stNext         = FS_DISA;
              flNext[FL_HEN] = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy         <= 1'b0;
      opQ          <= '0;
      idQ          <= '0;
      lenQ         <= '0;
      slotQ        <= '0;
      lstQ         <= '0;
      lflQ         <= '0;
      done         <= 1'b0;
      rspCode      <= '0;
      rspState     <= '0;
      rspFlags     <= '0;
      irqTeardown  <= 1'b0;
      xlatTeardown <= 1'b0;
      tdSlot       <= '0;
    end else if (busy) begin
      busy         <= 1'b0;
      done         <= 1'b1;
      rspCode      <= rcNext;
      rspState     <= stNext;
      rspFlags     <= flNext;
      irqTeardown  <= irqNext;
      xlatTeardown <= xlatNext;
      tdSlot       <= hitSlot;
    end else begin
      done         <= 1'b0;
      irqTeardown  <= 1'b0;
      xlatTeardown <= 1'b0;
      if (cmdValid) begin
        busy  <= 1'b1;
        opQ   <= cmdOp;
        idQ   <= cmdId;
        lenQ  <= cmdLen;
        slotQ <= cmdSlot;
        lstQ  <= cmdLoadState;
        lflQ  <= cmdLoadFlags;
      end
    end
  end

endmodule

// File: rtl/func_cfg_ctrl.sv
module func_cfg_ctrl
  import fcc_pkg::*;
#(
  parameter int NUM_FUNCS = 8,
  parameter int ID_W      = 32,
  parameter int LEN_W     = 16,
  parameter int MIN_LEN   = 16,
  localparam int SLOT_W   = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [ID_W-1:0]   cmdId,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic [SLOT_W-1:0] cmdSlot,
  input  logic [2:0]        cmdLoadState,
  input  logic [3:0]        cmdLoadFlags,
  output logic              done,
  output logic [15:0]       rspCode,
  output logic [2:0]        rspState,
  output logic [3:0]        rspFlags,
  output logic              irqTeardown,
  output logic              xlatTeardown,
  output logic [SLOT_W-1:0] tdSlot
);

  strobe_t           stb;
  logic [ID_W-1:0]   lookupId, loadId;
  logic [SLOT_W-1:0] loadSlot, hitSlot;
  logic [2:0]        loadState, hitState;
  logic [3:0]        loadFlags, hitFlags;
  logic              hit;

  fcc_control #(
    .ID_W(ID_W), .LEN_W(LEN_W), .SLOT_W(SLOT_W), .MIN_LEN(MIN_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdId(cmdId),
    .cmdLen(cmdLen), .cmdSlot(cmdSlot), .cmdLoadState(cmdLoadState),
    .cmdLoadFlags(cmdLoadFlags),
    .hit(hit), .hitSlot(hitSlot), .hitState(hitState), .hitFlags(hitFlags),
    .stb(stb), .lookupId(lookupId), .loadSlot(loadSlot), .loadId(loadId),
    .loadState(loadState), .loadFlags(loadFlags),
    .done(done), .rspCode(rspCode), .rspState(rspState), .rspFlags(rspFlags),
    .irqTeardown(irqTeardown), .xlatTeardown(xlatTeardown), .tdSlot(tdSlot)
  );

  fcc_table #(
    .NUM_FUNCS(NUM_FUNCS), .ID_W(ID_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk(clk), .rstN(rstN), .stb(stb),
    .loadSlot(loadSlot), .loadId(loadId), .loadState(loadState),
    .loadFlags(loadFlags), .lookupId(lookupId),
    .hit(hit), .hitSlot(hitSlot), .hitState(hitState), .hitFlags(hitFlags)
  );

endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
  import fcc_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic [2:0]       cmdOp,
  input logic [LEN_W-1:0] cmdLen,
  input logic             done,
  input logic [15:0]      rspCode,
  input logic [2:0]       rspState,
  input logic             irqTeardown,
  input logic             xlatTeardown
);

  logic [2:0] lastOp;
  logic       accept;

  assign accept = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN) lastOp <= '0;
    else if (accept) lastOp <= cmdOp;
  end

  // R8
  accept_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !cmdReady ##1 (done && cmdReady));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2
  short_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (cmdOp == OP_CFG || cmdOp == OP_DECFG) && cmdLen < LEN_W'(MIN_LEN))
    |=> ##1 (done && rspCode == RC_SHORT));

  // R10
  teardown_ctx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqTeardown || xlatTeardown) |-> (done && rspCode == RC_NORMAL));

  // R4
  cfg_to_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && lastOp == OP_CFG && rspCode == RC_NORMAL) |-> rspState == FS_DISA);

  // R6
  decfg_to_standby_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && lastOp == OP_DECFG && rspCode == RC_NORMAL) |-> rspState == FS_STBY);

  // R5
  inresv_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && rspCode == RC_INRESV) |-> rspState == FS_RESV);

endmodule

bind func_cfg_ctrl fcc_checker #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdOp(cmdOp), .cmdLen(cmdLen), .done(done), .rspCode(rspCode),
  .rspState(rspState), .irqTeardown(irqTeardown), .xlatTeardown(xlatTeardown)
);

// File: tb/tb_func_cfg_ctrl.sv
module tb_func_cfg_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_FUNCS  = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = '0;
  logic [31:0] cmdId = '0;
  logic [15:0] cmdLen = '0;
  logic [2:0]  cmdSlot = '0;
  logic [2:0]  cmdLoadState = '0;
  logic [3:0]  cmdLoadFlags = '0;
  logic        done;
  logic [15:0] rspCode;
  logic [2:0]  rspState;
  logic [3:0]  rspFlags;
  logic        irqTeardown, xlatTeardown;
  logic [2:0]  tdSlot;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] gRc;
  logic [2:0]  gSt;
  logic [3:0]  gFl;
  logic        gIrq, gX;
  logic [2:0]  gSlot;

  func_cfg_ctrl #(.NUM_FUNCS(NUM_FUNCS)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdId(cmdId), .cmdLen(cmdLen), .cmdSlot(cmdSlot),
    .cmdLoadState(cmdLoadState), .cmdLoadFlags(cmdLoadFlags),
    .done(done), .rspCode(rspCode), .rspState(rspState), .rspFlags(rspFlags),
    .irqTeardown(irqTeardown), .xlatTeardown(xlatTeardown), .tdSlot(tdSlot)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge of the done cycle
  task automatic issue(input logic [2:0] op, input logic [31:0] id,
                       input logic [15:0] len, input logic [2:0] slot,
                       input logic [2:0] lst, input logic [3:0] lfl);
    cmdOp = op; cmdId = id; cmdLen = len; cmdSlot = slot;
    cmdLoadState = lst; cmdLoadFlags = lfl; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R8", "ready low while busy", 32'(cmdReady), 32'd0);
    check("R8", "done not early", 32'(done), 32'd0);
    @(negedge clk);
    check("R8", "done pulse", 32'(done), 32'd1);
    check("R8", "ready back", 32'(cmdReady), 32'd1);
    gRc = rspCode; gSt = rspState; gFl = rspFlags;
    gIrq = irqTeardown; gX = xlatTeardown; gSlot = tdSlot;
  endtask

  task automatic loadEnt(input logic [2:0] slot, input logic [31:0] id,
                         input logic [2:0] st, input logic [3:0] fl);
    issue(3'd3, id, 16'd0, slot, st, fl);
    check("R1", "load code", 32'(gRc), 32'h0010);
    check("R1", "load state", 32'(gSt), 32'(st));
    check("R1", "load flags", 32'(gFl), 32'(fl));
  endtask

  task automatic query(input string req, input logic [31:0] id,
                       input logic [15:0] eRc, input logic [2:0] eSt,
                       input logic [3:0] eFl);
    issue(3'd4, id, 16'd0, 3'd0, 3'd0, 4'd0);
    check(req, "query code", 32'(gRc), 32'(eRc));
    check(req, "query state", 32'(gSt), 32'(eSt));
    check(req, "query flags", 32'(gFl), 32'(eFl));
    check(req, "query no teardown", 32'({gIrq, gX}), 32'd0);
  endtask

  // independent model: flags {mba,hen,xlat,irq}
  function automatic void model(input int op, input int st, input int fl,
                                output logic [15:0] rc, output int ns,
                                output int nf, output int itd, output int xtd);
    rc = 16'h0010; ns = st; nf = fl; itd = 0; xtd = 0;
    case (op)
      0: begin
        if (st == 0) rc = 16'h0AF0;
        else if (st == 1) ns = 2;
        else rc = 16'h0020;
      end
      1: begin
        if (st == 0) rc = 16'h0AF0;
        else if (st == 1) rc = 16'h0020;
        else begin ns = 1; nf = fl & 12; itd = fl & 1; xtd = (fl >> 1) & 1; end
      end
      default: begin
        if (st == 0) rc = 16'h0020;
        else begin
          itd = fl & 1; xtd = (fl >> 1) & 1;
          if (st == 1) nf = fl & 4;
          else begin ns = 2; nf = 0; end
        end
      end
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] nextId;
    nextId = 32'h1000_0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8", "reset ready", 32'(cmdReady), 32'd1);
    check("R8", "reset done", 32'(done), 32'd0);
    check("R10", "reset teardowns", 32'({irqTeardown, xlatTeardown}), 32'd0);
    check("R1", "reset code", 32'(rspCode), 32'd0);

    // R3: empty table, identifier 0 matches nothing
    query("R3", 32'd0, 16'h09F0, 3'd0, 4'd0);
    issue(3'd0, 32'h55, 16'd16, 3'd0, 3'd0, 4'd0);
    check("R3", "cfg unknown id", 32'(gRc), 32'h09F0);

    // state x flags x opcode sweep (R4 R5 R6 R7)
    for (int op = 0; op < 3; op++) begin
      for (int st = 0; st < 5; st++) begin
        for (int fl = 0; fl < 16; fl++) begin
          logic [15:0] eRc;
          int ns, nf, itd, xtd;
          logic [2:0] slot;
          string req;
          slot = 3'((st * 16 + fl + op) % NUM_FUNCS);
          req = (op == 0) ? "R4" : (op == 2) ? "R7" : (st < 2) ? "R5" : "R6";
          nextId = nextId + 1;
          loadEnt(slot, nextId, 3'(st), 4'(fl));
          model(op, st, fl, eRc, ns, nf, itd, xtd);
          issue(3'(op), nextId, 16'd16, 3'd0, 3'd0, 4'd0);
          check(req, "code", 32'(gRc), 32'(eRc));
          check(req, "state", 32'(gSt), 32'(ns));
          check(req, "flags", 32'(gFl), 32'(nf));
          check(req, "irq teardown", 32'(gIrq), 32'(itd));
          check(req, "xlat teardown", 32'(gX), 32'(xtd));
          if (itd != 0 || xtd != 0) check(req, "teardown slot", 32'(gSlot), 32'(slot));
          query(req, nextId, 16'h0010, 3'(ns), 4'(nf));
        end
      end
    end

    // R2: length sweep for configure and deconfigure
    for (int op = 0; op < 2; op++) begin
      for (int len = 0; len < 21; len++) begin
        logic [2:0] st0;
        st0 = (op == 0) ? 3'd1 : 3'd3;
        nextId = nextId + 1;
        loadEnt(3'd4, nextId, st0, 4'b0011);
        issue(3'(op), nextId, 16'(len), 3'd0, 3'd0, 4'd0);
        if (len < 16) begin
          check("R2", "short code", 32'(gRc), 32'h0300);
          check("R2", "short status", 32'({gSt, gFl}), 32'd0);
          check("R2", "short no teardown", 32'({gIrq, gX}), 32'd0);
          query("R2", nextId, 16'h0010, st0, 4'b0011);
        end else begin
          check("R2", "long code", 32'(gRc), 32'h0010);
          query("R2", nextId, 16'h0010, (op == 0) ? 3'd2 : 3'd1,
                (op == 0) ? 4'b0011 : 4'b0000);
        end
      end
    end
    issue(3'd1, 32'hDEAD_0000, 16'd3, 3'd0, 3'd0, 4'd0);
    check("R2", "length before lookup", 32'(gRc), 32'h0300);

    // R3: duplicate identifiers, lowest slot used
    loadEnt(3'd5, 32'hD0D0, 3'd2, 4'b0010);
    loadEnt(3'd2, 32'hD0D0, 3'd3, 4'b0001);
    issue(3'd1, 32'hD0D0, 16'd20, 3'd0, 3'd0, 4'd0);
    check("R3", "dup code", 32'(gRc), 32'h0010);
    check("R3", "dup irq td", 32'(gIrq), 32'd1);
    check("R3", "dup xlat td", 32'(gX), 32'd0);
    check("R3", "dup slot", 32'(gSlot), 32'd2);
    query("R3", 32'hD0D0, 16'h0010, 3'd1, 4'b0000);

    // R9: unused opcodes
    nextId = nextId + 1;
    loadEnt(3'd7, nextId, 3'd3, 4'b1111);
    for (int op = 5; op < 8; op++) begin
      issue(3'(op), nextId, 16'd16, 3'd7, 3'd0, 4'd0);
      check("R9", "bad op code", 32'(gRc), 32'h01F0);
      check("R9", "bad op status", 32'({gSt, gFl}), 32'd0);
      check("R10", "bad op no teardown", 32'({gIrq, gX}), 32'd0);
      query("R9", nextId, 16'h0010, 3'd3, 4'b1111);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule